// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Unit

This block maps a stream of 10-bit pixel samples onto 8-bit output samples through a programmable gamma transfer curve. The curve has fifteen knots at fixed, unevenly spaced input values. Each knot carries an 8-bit output level that software programs. An implied knot at input 0 has output 0. Samples that fall between two knots are linearly interpolated. Above the last knot the curve rises linearly to full scale at the largest input code. One sample is accepted on every clock. Each result leaves the block after a fixed latency, and its valid flag is the input valid delayed by that same latency.

Knot writes land in a staging copy of the curve. A small two-state controller tracks whether the staging copy differs from the copy in use:
- `CUR_SYNCED`: no write is outstanding. An accepted write moves it to `CUR_PENDING`.
- `CUR_PENDING`: at least one written knot is waiting. A frame-start pulse copies the staging curve into the active curve and returns the controller to `CUR_SYNCED`. If a new write arrives in the same cycle as that pulse, the controller stays in `CUR_PENDING`.

Because of this scheme, one frame is never processed with two different curves. When the enable input is low, a sample passes through as its top eight bits.

Top module: `gamma_pwl_unit`

## Requirements
- R1: After reset, `out_valid` is 0. The active and staging knot levels for indices 0 to 14 are, in hex, 02, 07, 1F, 49, 5A, 6A, 79, 87, 94, 9F, AF, BB, CF, EE and EE.
- R2: Knot index k (0 to 14) sits at input 0x010, 0x020, 0x040, 0x080, 0x0A0, 0x0C0, 0x0E0, 0x100, 0x120, 0x140, 0x180, 0x1C0, 0x240, 0x2C0 or 0x340 respectively. With enable high, an input exactly at a knot gives that knot's level. Input 0 gives 0.
- R3: With enable high, an input x with xa <= x < xb, where xa and xb are adjacent knot inputs (the first xa is 0 with level 0), gives ya + floor((yb - ya) * (x - xa) / (xb - xa)). This holds for falling curves as well as rising ones. Every such span is 16, 32, 64 or 128 wide.
- R4: With enable high, an input x at or above 0x340 gives y14 + floor((255 - y14) * (x - 0x340) / 191), where y14 is the level of knot 14. Input 0x3FF gives 0xFF.
- R5: With enable low, the output is input bits [9:2]. The enable is taken together with each sample.
- R6: `out_valid` equals `in_valid` delayed by exactly 3 clocks. Back-to-back samples give back-to-back results.
- R7: A write with `wr_en` high stores `wr_data` as the staging level of knot `wr_idx`. Only a later `frame_start` pulse moves the staging levels into use. A write in the same cycle as `frame_start` is used only after the next pulse.
- R8: A write with `wr_idx` of 15 changes no knot, neither now nor after a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 applies the curve, 0 passes the top 8 input bits |
| frame_start | input | 1 | One-cycle pulse that moves staged knots into use |
| wr_en | input | 1 | Knot write strobe |
| wr_idx | input | 4 | Knot index 0 to 14; 15 is ignored |
| wr_data | input | 8 | Knot output level |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 10 | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 8 | Output sample |

## Verification
The bench builds the unit with its default widths: 10-bit input, 8-bit output and fifteen knots. These widths let it drive every input code class. That covers each of the sixteen spans, both 16-wide spans next to the origin, the 191-wide tail whose divide is not a shift, and the corner code 0x3FF. Random knot programs make falling spans and negative slopes reachable, so the floor rounding of R3 is exercised. Writes are placed before, on and after frame-start pulses to separate the staged curve from the active one.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int IN_W   = 10;
    localparam int OUT_W  = 8;
    localparam int NPTS   = 15;
    localparam int SEG_W  = $clog2(NPTS + 1);
    localparam int DX_W   = 8;
    localparam int PROD_W = 2 * (OUT_W + 1);
    localparam int TOP_X  = (1 << IN_W) - 1;

    typedef enum logic [0:0] {
        CUR_SYNCED  = 1'b0,
        CUR_PENDING = 1'b1
    } curve_state_e;

    // Input coordinate of knot i; 0 is the origin, NPTS+1 is full scale.
    function automatic int knot_x(input int i);
        case (i)
            0:  return 0;
            1:  return 16;
            2:  return 32;
            3:  return 64;
            4:  return 128;
            5:  return 160;
            6:  return 192;
            7:  return 224;
            8:  return 256;
            9:  return 288;
            10: return 320;
            11: return 384;
            12: return 448;
            13: return 576;
            14: return 704;
            15: return 832;
            default: return TOP_X;
        endcase
    endfunction

    function automatic int seg_span(input int s);
        return knot_x(s + 1) - knot_x(s);
    endfunction

    function automatic int seg_shift(input int s);
        return $clog2(seg_span(s));
    endfunction

    // Reset level of programmable knot i (0 .. NPTS-1).
    function automatic logic [OUT_W-1:0] knot_reset(input int i);
        case (i)
            0:  return 8'h02;
            1:  return 8'h07;
            2:  return 8'h1F;
            3:  return 8'h49;
            4:  return 8'h5A;
            5:  return 8'h6A;
            6:  return 8'h79;
            7:  return 8'h87;
            8:  return 8'h94;
            9:  return 8'h9F;
            10: return 8'hAF;
            11: return 8'hBB;
            12: return 8'hCF;
            13: return 8'hEE;
            default: return 8'hEE;
        endcase
    endfunction
endpackage

// File: rtl/gamma_curve_regs.sv
module gamma_curve_regs
    import gamma_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_start,
    input  logic                            wr_en,
    input  logic [SEG_W-1:0]                wr_idx,
    input  logic [OUT_W-1:0]                wr_data,
    output logic [NPTS-1:0][OUT_W-1:0]      act_pts
);
    logic [NPTS-1:0][OUT_W-1:0] stg_pts;
    curve_state_e state, state_nx;
    logic wr_ok;
    logic commit;

    assign wr_ok = wr_en && (wr_idx < SEG_W'(NPTS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CUR_SYNCED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CUR_SYNCED:  if (wr_ok) state_nx = CUR_PENDING;
            CUR_PENDING: if (frame_start && !wr_ok) state_nx = CUR_SYNCED;
            default:     state_nx = CUR_SYNCED;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            CUR_SYNCED:  commit = 1'b0;
            CUR_PENDING: commit = frame_start;
            default:     commit = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NPTS; g++) begin : g_knot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_pts[g] <= knot_reset(g);
                act_pts[g] <= knot_reset(g);
            end else begin
                if (wr_ok && (wr_idx == SEG_W'(g))) stg_pts[g] <= wr_data;
                if (commit) act_pts[g] <= stg_pts[g];
            end
        end
    end

    // R7: the active curve moves only on a frame start.
    p_hold_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_pts));
    // R7: after a frame start, the active curve equals the staging curve that stood before it.
    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> act_pts == $past(stg_pts));
    // R8: a write to an index out of range leaves the staging curve untouched.
    p_ignore_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= SEG_W'(NPTS)) |=> $stable(stg_pts));
endmodule

// File: rtl/gamma_seg_lookup.sv
module gamma_seg_lookup
    import gamma_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            valid_i,
    input  logic                            byp_i,
    input  logic [IN_W-1:0]                 data_i,
    input  logic [NPTS-1:0][OUT_W-1:0]      act_pts,
    output logic                            valid_o,
    output logic                            byp_o,
    output logic [OUT_W-1:0]                byp_data_o,
    output logic [SEG_W-1:0]                seg_o,
    output logic [OUT_W-1:0]                ya_o,
    output logic signed [OUT_W:0]           dy_o,
    output logic [DX_W-1:0]                 dx_o
);
    logic [NPTS-1:0]   past_knot;
    logic [SEG_W-1:0]  seg;
    logic [OUT_W-1:0]  pts_ext [NPTS+2];
    logic [OUT_W-1:0]  ya, yb;
    logic [IN_W-1:0]   xbase;
    logic [IN_W-1:0]   dx_full;
    logic [IN_W-1:0]   span;

    for (genvar g = 0; g < NPTS; g++) begin : g_cmp
        localparam logic [IN_W-1:0] KX = IN_W'(knot_x(g + 1));
        assign past_knot[g]  = data_i >= KX;
        assign pts_ext[g+1]  = act_pts[g];
    end
    assign pts_ext[0]      = '0;
    assign pts_ext[NPTS+1] = '1;

    always_comb begin
        seg = '0;
        for (int i = 0; i < NPTS; i++) seg = seg + SEG_W'(past_knot[i]);
    end

    always_comb begin
        ya    = '0;
        yb    = '0;
        xbase = '0;
        span  = '0;
        for (int i = 0; i <= NPTS; i++) begin
            if (seg == SEG_W'(i)) begin
                ya    = pts_ext[i];
                yb    = pts_ext[i+1];
                xbase = IN_W'(knot_x(i));
                span  = IN_W'(seg_span(i));
            end
        end
    end

    assign dx_full = data_i - xbase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            byp_o      <= 1'b0;
            byp_data_o <= '0;
            seg_o      <= '0;
            ya_o       <= '0;
            dy_o       <= '0;
            dx_o       <= '0;
        end else begin
            valid_o    <= valid_i;
            byp_o      <= byp_i;
            byp_data_o <= data_i[IN_W-1 -: OUT_W];
            seg_o      <= seg;
            ya_o       <= ya;
            dy_o       <= $signed({1'b0, yb}) - $signed({1'b0, ya});
            dx_o       <= dx_full[DX_W-1:0];
        end
    end

    // R3: the chosen span contains the sample; the offset stays below the span width.
    p_dx_in_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (dx_full < span || (seg == SEG_W'(NPTS) && dx_full <= span)));
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
    import gamma_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic                    byp_i,
    input  logic [OUT_W-1:0]        byp_data_i,
    input  logic [SEG_W-1:0]        seg_i,
    input  logic [OUT_W-1:0]        ya_i,
    input  logic signed [OUT_W:0]   dy_i,
    input  logic [DX_W-1:0]         dx_i,
    output logic                    valid_o,
    output logic [OUT_W-1:0]        data_o
);
    localparam logic signed [PROD_W-1:0] LAST_DIV = PROD_W'(seg_span(NPTS));

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] quo;
    logic signed [PROD_W-1:0] sum;
    logic [OUT_W-1:0]         lo_b, hi_b;
    logic [OUT_W-1:0]         yb_chk;

    assign prod = dy_i * $signed({1'b0, dx_i});

    always_comb begin
        quo = prod / LAST_DIV;
        for (int i = 0; i < NPTS; i++) begin
            if (seg_i == SEG_W'(i)) quo = prod >>> seg_shift(i);
        end
    end

    assign sum = $signed({{(PROD_W-OUT_W){1'b0}}, ya_i}) + quo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= valid_i;
            data_o  <= byp_i ? byp_data_i : sum[OUT_W-1:0];
        end
    end

    assign yb_chk = OUT_W'($signed({1'b0, ya_i}) + dy_i);
    assign lo_b   = (dy_i < 0) ? yb_chk : ya_i;
    assign hi_b   = (dy_i < 0) ? ya_i : yb_chk;

    // R3: the interpolated level never leaves the byte range.
    p_sum_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !byp_i) |-> (sum >= 0 && sum <= PROD_W'((1 << OUT_W) - 1)));
    // R3: the result lies between the levels of the two knots that bound the span.
    p_between_knots_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !byp_i) |=> (data_o >= $past(lo_b) && data_o <= $past(hi_b)));
endmodule

// File: rtl/gamma_pwl_unit.sv
module gamma_pwl_unit
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_start,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              in_valid,
    input  logic [9:0]        in_data,
    output logic              out_valid,
    output logic [7:0]        out_data
);
    localparam int LATENCY = 3;

    logic                       s1_valid, s1_byp;
    logic [IN_W-1:0]            s1_data;
    logic [NPTS-1:0][OUT_W-1:0] act_pts;
    logic                       s2_valid, s2_byp;
    logic [OUT_W-1:0]           s2_byp_data, s2_ya;
    logic [SEG_W-1:0]           s2_seg;
    logic signed [OUT_W:0]      s2_dy;
    logic [DX_W-1:0]            s2_dx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_byp   <= 1'b0;
            s1_data  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_byp   <= !enable;
            s1_data  <= in_data;
        end
    end

    gamma_curve_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .act_pts     (act_pts)
    );

    gamma_seg_lookup u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (s1_valid),
        .byp_i      (s1_byp),
        .data_i     (s1_data),
        .act_pts    (act_pts),
        .valid_o    (s2_valid),
        .byp_o      (s2_byp),
        .byp_data_o (s2_byp_data),
        .seg_o      (s2_seg),
        .ya_o       (s2_ya),
        .dy_o       (s2_dy),
        .dx_o       (s2_dx)
    );

    gamma_interp u_interp (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (s2_valid),
        .byp_i      (s2_byp),
        .byp_data_i (s2_byp_data),
        .seg_i      (s2_seg),
        .ya_i       (s2_ya),
        .dy_i       (s2_dy),
        .dx_i       (s2_dx),
        .valid_o    (out_valid),
        .data_o     (out_data)
    );

    // Cycles since reset, saturating, so that $past never reaches into reset.
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               age <= '0;
        else if (age != 2'd3)     age <= age + 2'd1;
    end

    // R6: output valid is the input valid three clocks earlier.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY)));
    // R5: a sample taken with enable low comes out as its top bits.
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'(LATENCY) && $past(in_valid && !enable, LATENCY))
        |-> (out_data == $past(in_data[9:2], LATENCY)));
    // R1: nothing valid leaves the block in the first cycles after reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'(LATENCY)) |-> !out_valid);
endmodule

// File: tb/tb_gamma_pwl_unit.sv
`timescale 1ns/1ps
module tb_gamma_pwl_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       frame_start = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = '0;
    logic       out_valid;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit run_chk = 0;
    logic [2:0] vhist = '0;

    int bp   [0:16];
    int act_m[0:16];
    int stg_m[0:16];
    int exp_q[$];
    string tag_q[$];

    gamma_pwl_unit dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    function automatic int fdiv(input int num, input int den);
        if (num >= 0) return num / den;
        return -((-num + den - 1) / den);
    endfunction

    function automatic int model(input int x, input bit en);
        int s, xa, w, ya, yb;
        if (!en) return x / 4;
        s = 0;
        for (int k = 1; k <= 15; k++) if (x >= bp[k]) s = k;
        xa = bp[s];
        ya = act_m[s];
        if (s == 15) begin w = 191; yb = 255; end
        else begin w = bp[s+1] - bp[s]; yb = act_m[s+1]; end
        return ya + fdiv((yb - ya) * (x - xa), w);
    endfunction

    function automatic string cls(input int x, input bit en);
        if (!en) return "R5";
        if (x >= 832) return "R4";
        for (int k = 0; k <= 15; k++) if (x == bp[k]) return "R2";
        return "R3";
    endfunction

    always @(negedge clk) begin
        if (run_chk) begin
            check("R6 valid", int'(out_valid), int'(vhist[2]));
            if (out_valid) begin
                if (exp_q.size() == 0) check("R6 extra", 1, 0);
                else check(tag_q.pop_front(), int'(out_data), exp_q.pop_front());
            end
            vhist = {vhist[1:0], in_valid};
        end
    end

    task automatic send(input int x, input bit en, input string tag);
        @(posedge clk); #2;
        in_valid = 1'b1; in_data = 10'(x); enable = en;
        wr_en = 1'b0; frame_start = 1'b0;
        exp_q.push_back(model(x, en));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b0; wr_en = 1'b0; frame_start = 1'b0;
        end
    endtask

    task automatic ctl(input bit we, input int idx, input int val, input bit fs);
        @(posedge clk); #2;
        in_valid = 1'b0;
        wr_en = we; wr_idx = 4'(idx); wr_data = 8'(val); frame_start = fs;
        if (fs) for (int k = 1; k <= 15; k++) act_m[k] = stg_m[k];
        if (we && idx < 15) stg_m[idx+1] = val;
    endtask

    initial begin
        int sd;
        int x;
        bit en;
        int vals[0:14] = '{2, 7, 31, 73, 90, 106, 121, 135, 148, 159, 175, 187, 207, 238, 238};
        bp = '{0, 16, 32, 64, 128, 160, 192, 224, 256, 288, 320, 384, 448, 576, 704, 832, 1023};
        act_m[0] = 0; stg_m[0] = 0;
        for (int k = 1; k <= 15; k++) begin act_m[k] = vals[k-1]; stg_m[k] = vals[k-1]; end
        sd = $urandom(32'd20240611);

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        run_chk = 1;

        // R1: reset levels visible at every knot
        for (int k = 1; k <= 15; k++) send(bp[k], 1'b1, "R1");
        send(0, 1'b1, "R2");
        send(1023, 1'b1, "R4");
        send(833, 1'b1, "R4");
        send(8, 1'b1, "R3");
        send(831, 1'b1, "R3");
        send(1023, 1'b0, "R5");
        send(3, 1'b0, "R5");
        idle(5);

        // random stream with gaps and mixed enable
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            x = $urandom_range(0, 1023);
            en = ($urandom_range(0, 4) != 0);
            send(x, en, cls(x, en));
        end
        idle(5);

        // R7: write a random curve but do not commit yet
        for (int k = 0; k < 15; k++) ctl(1'b1, k, $urandom_range(0, 255), 1'b0);
        ctl(1'b1, 15, 8'h5A, 1'b0);  // R8: out-of-range index
        for (int k = 1; k <= 15; k++) send(bp[k], 1'b1, "R7 staged not used");
        idle(5);

        // commit, with a simultaneous write to knot 3 that must wait
        ctl(1'b1, 3, 8'hC3, 1'b1);
        idle(2);
        for (int k = 1; k <= 15; k++) send(bp[k], 1'b1, "R7 committed");
        send(128, 1'b1, "R7 same-cycle write deferred");
        for (int i = 0; i < 600; i++) begin
            x = $urandom_range(0, 1023);
            send(x, 1'b1, cls(x, 1'b1));
        end
        idle(5);
        ctl(1'b0, 0, 0, 1'b1);
        idle(2);
        send(128, 1'b1, "R7 deferred write applied");
        send(832, 1'b1, "R8 knot 14 unchanged");
        send(1023, 1'b1, "R4");
        ctl(1'b1, 15, 8'h11, 1'b0);
        ctl(1'b0, 0, 0, 1'b1);
        idle(2);
        for (int k = 1; k <= 15; k++) send(bp[k], 1'b1, "R8 after ignored write");
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 2) == 0) idle(1);
            x = $urandom_range(0, 1023);
            en = $urandom_range(0, 1) == 1;
            send(x, en, cls(x, en));
        end
        idle(6);
        check("R6 all results drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule